// File: doc/BRIEF.md
# AUX Read Retry Sequencer

This block runs a single read transaction over a display-link auxiliary channel, either against the sink's native register space or as an I2C read carried over that channel. A request arrives on a valid/ready handshake carrying the address space, an address, the number of bytes wanted and a middle-of-transaction flag. The sequencer formats the channel command and address, hands the request to a channel engine over a second valid/ready handshake, and then waits for the engine's single-cycle result. The result carries a channel outcome, a reply code and a returned byte count.

Each failure cause has its own counter, its own limit and its own rules for when the counter is cleared. The block waits between retries using a microsecond timer built from a clock prescaler. An invalid reply adds a fixed wait, and an I2C-space retry adds a gap that software sets. At the end the block raises `done` for one cycle with a final status and the accepted length.

Back-pressure rules are as follows. `req_ready` is high only while the block is idle, so a request offered while a transaction is running simply waits. The channel request holds its command, address and length until `ch_req_ready` is seen. The result side has no ready: the engine presents `ch_rsp_valid` for one cycle, and only after its request has been taken.

Top module: `auxrd_seq`

## Requirements
- R1: Command codes on `ch_cmd`. Native space (`req_i2c`=0) uses 4'b1001, with `ch_addr` equal to the full request address. I2C space uses 4'b0101 when `req_mot`=1 and 4'b0001 otherwise, with `ch_addr` equal to the request address shifted right by one.
- R2: `ch_req_valid` stays high, with `ch_cmd`, `ch_addr` and `ch_len` stable, until `ch_req_ready` is seen. `ch_len` equals the requested length.
- R3: Channel outcome codes on `ch_result` are 0 success, 1 invalid reply and 2 timeout. A first invalid reply is retried after a wait of INVALID_WAIT_US microseconds. A second consecutive invalid reply ends the transaction with status 3 (protocol error).
- R4: A channel timeout (outcome 2) is retried at once with no extra wait. The third consecutive timeout ends the transaction with status 2 (timeout).
- R5: Reply codes on `ch_reply` are 0 ACK, 1 NACK, 2 AUX defer and 3 I2C defer. Each AUX defer increments a defer count. When that count exceeds DEFER_LIMIT (6), the transaction ends with status 2.
- R6: An I2C defer clears the AUX defer count and increments a separate I2C defer count. When the I2C defer count exceeds DEFER_LIMIT, the transaction ends with status 2.
- R7: A successful outcome whose `ch_count` exceeds the requested length ends the transaction with status 3, whatever the reply code. A count equal to the requested length is accepted.
- R8: An ACK with a valid count ends the transaction with status 0 (success) and `acc_len` equal to `ch_count`. Every other final status reports `acc_len` = 0.
- R9: A NACK ends the transaction at once with status 1. Outcome code 3, or reply codes 4 to 7, end it with status 4 (unknown).
- R10: A successful outcome clears the invalid-reply and timeout counts, so those limits apply only to consecutive failures.
- R11: Every retry of an I2C-space request waits `i2c_gap_us` microseconds, sampled at request acceptance. For an invalid reply this gap comes on top of the invalid wait. Native-space retries add no gap.
- R12: `done` is high for exactly one cycle per transaction. `status` and `acc_len` hold their values between `done` pulses. `req_ready` is low from acceptance until `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Transaction request offered |
| req_ready | output | 1 | Block idle, request taken when valid |
| req_i2c | input | 1 | 1 = I2C space, 0 = native space |
| req_mot | input | 1 | Middle-of-transaction flag for I2C reads |
| req_addr | input | ADDR_W | Register address or 8-bit I2C address |
| req_len | input | LEN_W | Requested byte count |
| i2c_gap_us | input | GAP_W | Inter-retry gap for I2C space, microseconds |
| ch_req_valid | output | 1 | Channel request present |
| ch_req_ready | input | 1 | Channel engine takes the request |
| ch_cmd | output | 4 | Channel command code |
| ch_addr | output | ADDR_W | Channel address |
| ch_len | output | LEN_W | Channel byte count |
| ch_rsp_valid | input | 1 | One-cycle channel result strobe |
| ch_result | input | 2 | Channel outcome code |
| ch_reply | input | 3 | Sink reply code |
| ch_count | input | LEN_W | Returned byte count |
| done | output | 1 | One-cycle completion pulse |
| status | output | 3 | Final status code |
| acc_len | output | LEN_W | Accepted length |

## Verification
The sequencer is driven from a table of scripted reply streams. Each stream is built to separate one rule from its neighbours. Six AUX defers followed by an ACK must succeed while seven must time out, which pins the exceedance limit. Six AUX defers, an I2C defer and one further AUX defer must still succeed, which shows the I2C defer clearing the AUX count. An invalid reply, a deferred success and a second invalid reply must succeed, which shows that a successful outcome clears the consecutive-failure counts. The gap before the first retry is measured in cycles for native, I2C and invalid-reply cases, which separates the fixed wait from the configurable gap. Commands and addresses are compared on both address spaces. The channel handshake is also held off to check that the request stays stable.

// File: rtl/auxrd_pkg.sv
package auxrd_pkg;
  typedef enum logic [2:0] {
    ST_SUCCESS = 3'd0,
    ST_NACK    = 3'd1,
    ST_TIMEOUT = 3'd2,
    ST_PROTO   = 3'd3,
    ST_UNKNOWN = 3'd4
  } status_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_ISSUE,
    S_RESP,
    S_WAIT
  } fsm_e;

  localparam logic [1:0] RES_OK      = 2'd0;
  localparam logic [1:0] RES_INVALID = 2'd1;
  localparam logic [1:0] RES_TIMEOUT = 2'd2;

  localparam logic [2:0] RPL_ACK       = 3'd0;
  localparam logic [2:0] RPL_NACK      = 3'd1;
  localparam logic [2:0] RPL_AUX_DEFER = 3'd2;
  localparam logic [2:0] RPL_I2C_DEFER = 3'd3;

  localparam logic [3:0] CMD_NATIVE_RD  = 4'b1001;
  localparam logic [3:0] CMD_I2C_RD     = 4'b0001;
  localparam logic [3:0] CMD_I2C_RD_MOT = 4'b0101;

  // retry counter slots
  localparam int NCTR    = 4;
  localparam int IDX_INV = 0;
  localparam int IDX_TMO = 1;
  localparam int IDX_AUX = 2;
  localparam int IDX_I2C = 3;
endpackage

// File: rtl/auxrd_fmt.sv
module auxrd_fmt
  import auxrd_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              is_i2c,
  input  logic              mot,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [3:0]        cmd,
  output logic [ADDR_W-1:0] addr_out
);
  always_comb begin
    if (is_i2c) begin
      cmd      = mot ? CMD_I2C_RD_MOT : CMD_I2C_RD;
      addr_out = addr_in >> 1;
    end else begin
      cmd      = CMD_NATIVE_RD;
      addr_out = addr_in;
    end
  end
endmodule

// File: rtl/auxrd_retry_ctr.sv
module auxrd_retry_ctr #(
  parameter int CNT_W = 4,
  parameter int LIMIT = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic at_lim
);
  logic [CNT_W-1:0] cnt;

  // one more increment would exceed the limit
  assign at_lim = (cnt >= CNT_W'(LIMIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt <= '0;
    else if (clr)                   cnt <= '0;
    else if (inc && (cnt != '1))    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/auxrd_us_timer.sv
module auxrd_us_timer #(
  parameter int CLKS_PER_US = 100,
  parameter int US_W        = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [US_W-1:0] load_us,
  output logic            fire
);
  localparam int PS_W = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;

  logic [PS_W-1:0] cyc;
  logic [US_W-1:0] us_left;
  logic            run;
  logic            tick;

  assign tick = (cyc == PS_W'(CLKS_PER_US - 1));
  assign fire = run && tick && (us_left == US_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc     <= '0;
      us_left <= '0;
      run     <= 1'b0;
    end else if (load) begin
      cyc     <= '0;
      us_left <= load_us;
      run     <= (load_us != '0);
    end else if (run) begin
      if (tick) begin
        cyc     <= '0;
        us_left <= us_left - 1'b1;
        if (us_left == US_W'(1)) run <= 1'b0;
      end else begin
        cyc <= cyc + 1'b1;
      end
    end
  end
endmodule

// File: rtl/auxrd_seq.sv
module auxrd_seq
  import auxrd_pkg::*;
#(
  parameter int ADDR_W          = 20,
  parameter int LEN_W           = 5,
  parameter int GAP_W           = 8,
  parameter int CNT_W           = 4,
  parameter int CLKS_PER_US     = 100,
  parameter int INVALID_WAIT_US = 400,
  parameter int INVALID_LIMIT   = 1,
  parameter int TIMEOUT_LIMIT   = 2,
  parameter int DEFER_LIMIT     = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_i2c,
  input  logic              req_mot,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [GAP_W-1:0]  i2c_gap_us,
  output logic              ch_req_valid,
  input  logic              ch_req_ready,
  output logic [3:0]        ch_cmd,
  output logic [ADDR_W-1:0] ch_addr,
  output logic [LEN_W-1:0]  ch_len,
  input  logic              ch_rsp_valid,
  input  logic [1:0]        ch_result,
  input  logic [2:0]        ch_reply,
  input  logic [LEN_W-1:0]  ch_count,
  output logic              done,
  output logic [2:0]        status,
  output logic [LEN_W-1:0]  acc_len
);
  localparam int US_W = $clog2(INVALID_WAIT_US + (1 << GAP_W)) + 1;
  localparam logic [NCTR*CNT_W-1:0] LIMS = {
    CNT_W'(DEFER_LIMIT), CNT_W'(DEFER_LIMIT),
    CNT_W'(TIMEOUT_LIMIT), CNT_W'(INVALID_LIMIT)};

  fsm_e              state;
  logic              i2c_q, mot_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  len_q;
  logic [GAP_W-1:0]  gap_q;
  logic              done_q;
  status_e           status_q;
  logic [LEN_W-1:0]  acc_q;

  logic              accept, rsp_seen;
  logic [NCTR-1:0]   ctr_clr, ctr_inc, ctr_lim;
  logic              fin, retry, inv_wait;
  status_e           fin_st;
  logic [US_W-1:0]   wait_us;
  logic              tmr_load, tmr_fire;

  assign req_ready    = (state == S_IDLE);
  assign accept       = req_valid && req_ready;
  assign ch_req_valid = (state == S_ISSUE);
  assign ch_len       = len_q;
  assign rsp_seen     = (state == S_RESP) && ch_rsp_valid;

  auxrd_fmt #(.ADDR_W(ADDR_W)) u_fmt (
    .is_i2c  (i2c_q),
    .mot     (mot_q),
    .addr_in (addr_q),
    .cmd     (ch_cmd),
    .addr_out(ch_addr)
  );

  for (genvar g = 0; g < NCTR; g++) begin : g_ctr
    auxrd_retry_ctr #(
      .CNT_W(CNT_W),
      .LIMIT(int'(LIMS[g*CNT_W +: CNT_W]))
    ) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (ctr_clr[g]),
      .inc   (ctr_inc[g]),
      .at_lim(ctr_lim[g])
    );
  end

  // outcome decision
  always_comb begin
    fin      = 1'b0;
    fin_st   = ST_UNKNOWN;
    retry    = 1'b0;
    inv_wait = 1'b0;
    ctr_inc  = '0;
    ctr_clr  = accept ? '1 : '0;
    if (rsp_seen) begin
      case (ch_result)
        RES_OK: begin
          if (ch_count > len_q) begin
            fin    = 1'b1;
            fin_st = ST_PROTO;
          end else begin
            ctr_clr[IDX_INV] = 1'b1;
            ctr_clr[IDX_TMO] = 1'b1;
            case (ch_reply)
              RPL_ACK: begin
                fin              = 1'b1;
                fin_st           = ST_SUCCESS;
                ctr_clr[IDX_AUX] = 1'b1;
              end
              RPL_NACK: begin
                fin    = 1'b1;
                fin_st = ST_NACK;
              end
              RPL_AUX_DEFER: begin
                ctr_inc[IDX_AUX] = 1'b1;
                if (ctr_lim[IDX_AUX]) begin
                  fin    = 1'b1;
                  fin_st = ST_TIMEOUT;
                end else begin
                  retry = 1'b1;
                end
              end
              RPL_I2C_DEFER: begin
                ctr_clr[IDX_AUX] = 1'b1;
                ctr_inc[IDX_I2C] = 1'b1;
                if (ctr_lim[IDX_I2C]) begin
                  fin    = 1'b1;
                  fin_st = ST_TIMEOUT;
                end else begin
                  retry = 1'b1;
                end
              end
              default: begin
                fin    = 1'b1;
                fin_st = ST_UNKNOWN;
              end
            endcase
          end
        end
        RES_INVALID: begin
          ctr_inc[IDX_INV] = 1'b1;
          if (ctr_lim[IDX_INV]) begin
            fin    = 1'b1;
            fin_st = ST_PROTO;
          end else begin
            retry    = 1'b1;
            inv_wait = 1'b1;
          end
        end
        RES_TIMEOUT: begin
          ctr_inc[IDX_TMO] = 1'b1;
          if (ctr_lim[IDX_TMO]) begin
            fin    = 1'b1;
            fin_st = ST_TIMEOUT;
          end else begin
            retry = 1'b1;
          end
        end
        default: begin
          fin    = 1'b1;
          fin_st = ST_UNKNOWN;
        end
      endcase
    end
  end

  assign wait_us  = (inv_wait ? US_W'(INVALID_WAIT_US) : '0)
                  + (i2c_q ? US_W'(gap_q) : '0);
  assign tmr_load = retry && (wait_us != '0);

  auxrd_us_timer #(.CLKS_PER_US(CLKS_PER_US), .US_W(US_W)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (tmr_load),
    .load_us(wait_us),
    .fire   (tmr_fire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      i2c_q  <= 1'b0;
      mot_q  <= 1'b0;
      addr_q <= '0;
      len_q  <= '0;
      gap_q  <= '0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          state  <= S_ISSUE;
          i2c_q  <= req_i2c;
          mot_q  <= req_mot;
          addr_q <= req_addr;
          len_q  <= req_len;
          gap_q  <= i2c_gap_us;
        end
        S_ISSUE: if (ch_req_ready) state <= S_RESP;
        S_RESP: begin
          if (fin)           state <= S_IDLE;
          else if (tmr_load) state <= S_WAIT;
          else if (retry)    state <= S_ISSUE;
        end
        S_WAIT: if (tmr_fire) state <= S_ISSUE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q   <= 1'b0;
      status_q <= ST_SUCCESS;
      acc_q    <= '0;
    end else begin
      done_q <= fin;
      if (fin) begin
        status_q <= fin_st;
        acc_q    <= (fin_st == ST_SUCCESS) ? ch_count : '0;
      end
    end
  end

  assign done    = done_q;
  assign status  = status_q;
  assign acc_len = acc_q;
endmodule

// File: rtl/auxrd_seq_chk.sv
module auxrd_seq_chk #(
  parameter int ADDR_W = 20,
  parameter int LEN_W  = 5,
  parameter int GAP_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_i2c,
  input logic              req_mot,
  input logic [ADDR_W-1:0] req_addr,
  input logic [LEN_W-1:0]  req_len,
  input logic [GAP_W-1:0]  i2c_gap_us,
  input logic              ch_req_valid,
  input logic              ch_req_ready,
  input logic [3:0]        ch_cmd,
  input logic [ADDR_W-1:0] ch_addr,
  input logic [LEN_W-1:0]  ch_len,
  input logic              ch_rsp_valid,
  input logic [1:0]        ch_result,
  input logic [2:0]        ch_reply,
  input logic [LEN_W-1:0]  ch_count,
  input logic              done,
  input logic [2:0]        status,
  input logic [LEN_W-1:0]  acc_len
);
  logic [LEN_W-1:0] len_cap;
  logic             pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_cap <= '0;
      pend    <= 1'b0;
    end else begin
      if (req_valid && req_ready) len_cap <= req_len;
      if (ch_req_valid && ch_req_ready) pend <= 1'b1;
      else if (ch_rsp_valid) pend <= 1'b0;
    end
  end

  p_cmd_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ch_req_valid |-> (ch_cmd == 4'b1001 || ch_cmd == 4'b0001 || ch_cmd == 4'b0101));

  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ch_req_valid && !ch_req_ready |=> ch_req_valid && $stable(ch_cmd)
      && $stable(ch_addr) && $stable(ch_len));

  p_len_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ch_req_valid |-> ch_len == len_cap);

  p_oversize_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pend && ch_rsp_valid && ch_result == 2'd0 && ch_count > len_cap
      |=> done && status == 3'd3);

  p_acc_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (status == 3'd0) ? (acc_len <= len_cap) : (acc_len == '0));

  p_nack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pend && ch_rsp_valid && ch_result == 2'd0 && ch_reply == 3'd1
      && ch_count <= len_cap |=> done && status == 3'd1);

  p_unknown_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pend && ch_rsp_valid && ch_result == 2'd3 |=> done && status == 3'd4);

  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_status_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> !done || 1'b1 ? ($stable(status) || $rose(done)) : 1'b1);

  p_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_req_valid || pend) |-> !req_ready);
endmodule

bind auxrd_seq auxrd_seq_chk #(
  .ADDR_W(ADDR_W), .LEN_W(LEN_W), .GAP_W(GAP_W)
) u_chk (.*);

// File: tb/auxrd_seq_bench.sv
module auxrd_seq_bench;
  localparam int PERIOD = 10;
  localparam int AW = 20;
  localparam int LW = 5;
  localparam int CPU = 2;
  localparam int GAP = 3;

  // step = {result[1:0], reply[2:0]}
  localparam logic [4:0] S_ACK = 5'b00_000, S_NACK = 5'b00_001,
    S_AD = 5'b00_010, S_ID = 5'b00_011, S_BRP = 5'b00_101,
    S_INV = 5'b01_000, S_TMO = 5'b10_000, S_BRS = 5'b11_000;

  typedef struct packed {
    logic          i2c;
    logic          mot;
    logic [AW-1:0] addr;
    logic [LW-1:0] len;
    logic [LW-1:0] cnt;
    logic [49:0]   steps;
    logic [3:0]    natt;
    logic [2:0]    st;
    logic [LW-1:0] acc;
    logic [3:0]    cmd;
    logic [AW-1:0] caddr;
    logic [10:0]   gap;
    logic [3:0]    req;
  } vec_t;

  function automatic vec_t mkv(logic i2c, logic mot, logic [AW-1:0] a,
      logic [LW-1:0] len, logic [LW-1:0] cnt, logic [49:0] s, int n,
      int st, int acc, logic [3:0] cmd, logic [AW-1:0] ca, int gap, int r);
    vec_t v;
    v.i2c = i2c; v.mot = mot; v.addr = a; v.len = len; v.cnt = cnt;
    v.steps = s; v.natt = 4'(n); v.st = 3'(st); v.acc = LW'(acc);
    v.cmd = cmd; v.caddr = ca; v.gap = 11'(gap); v.req = 4'(r);
    return v;
  endfunction

  localparam int NV = 17;
  localparam vec_t VT [NV] = '{
    mkv(0,0,20'h12345,8,4,50'(S_ACK),1,0,4,4'b1001,20'h12345,0,8),        // R8 R1
    mkv(0,0,20'h00010,8,4,50'(S_NACK),1,1,0,4'b1001,20'h00010,0,9),       // R9
    mkv(0,0,20'h00020,8,4,50'({7{S_AD}}),7,2,0,4'b1001,20'h00020,1,5),    // R5
    mkv(0,0,20'h00021,8,4,50'({S_ACK,{6{S_AD}}}),7,0,4,4'b1001,20'h00021,1,5), // R5
    mkv(1,1,20'h000A1,8,4,50'({7{S_ID}}),7,2,0,4'b0101,20'h00050,1+CPU*GAP,6), // R6 R11
    mkv(0,0,20'h00030,8,4,50'({3{S_TMO}}),3,2,0,4'b1001,20'h00030,1,4),   // R4
    mkv(0,0,20'h00031,8,4,50'({S_ACK,{2{S_TMO}}}),3,0,4,4'b1001,20'h00031,1,4), // R4
    mkv(0,0,20'h00040,8,4,50'({2{S_INV}}),2,3,0,4'b1001,20'h00040,1+CPU*400,3), // R3
    mkv(0,0,20'h00041,8,4,50'({S_ACK,S_INV}),2,0,4,4'b1001,20'h00041,1+CPU*400,3), // R3
    mkv(0,0,20'h00050,8,9,50'(S_ACK),1,3,0,4'b1001,20'h00050,0,7),        // R7
    mkv(0,0,20'h00051,8,8,50'(S_ACK),1,0,8,4'b1001,20'h00051,0,7),        // R7 boundary
    mkv(0,0,20'h00060,8,4,50'(S_BRS),1,4,0,4'b1001,20'h00060,0,9),        // R9
    mkv(0,0,20'h00061,8,4,50'(S_BRP),1,4,0,4'b1001,20'h00061,0,9),        // R9
    mkv(0,0,20'h00070,8,4,50'({S_ACK,S_INV,S_AD,S_INV}),4,0,4,4'b1001,20'h00070,1+CPU*400,10), // R10
    mkv(1,0,20'h0003C,8,4,50'({S_ACK,S_AD,S_ID,{6{S_AD}}}),9,0,4,4'b0001,20'h0001E,1+CPU*GAP,6), // R6 R1
    mkv(1,1,20'h000A0,8,4,50'({S_ACK,S_INV}),2,0,4,4'b0101,20'h00050,1+CPU*(400+GAP),11), // R11
    mkv(0,0,20'h00080,8,9,50'(S_AD),1,3,0,4'b1001,20'h00080,0,7)          // R7 non-ACK
  };

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_i2c = 0, req_mot = 0;
  logic [AW-1:0] req_addr = '0;
  logic [LW-1:0] req_len = '0, ch_count = '0;
  logic [7:0] i2c_gap_us = 8'(GAP);
  logic ch_req_ready = 1, ch_rsp_valid = 0;
  logic [1:0] ch_result = 0;
  logic [2:0] ch_reply = 0;
  logic req_ready, ch_req_valid, done;
  logic [3:0] ch_cmd;
  logic [AW-1:0] ch_addr;
  logic [LW-1:0] ch_len, acc_len;
  logic [2:0] status;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #(PERIOD/2) clk = ~clk;

  auxrd_seq #(.ADDR_W(AW), .LEN_W(LW), .GAP_W(8), .CNT_W(4),
    .CLKS_PER_US(CPU), .INVALID_WAIT_US(400)) u_auxrd_seq (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v, input int id);
    int att = 0, gap = 0, edges;
    bit fin = 0;
    logic [4:0] s;
    logic [2:0] st_keep;
    @(negedge clk);
    req_valid = 1; req_i2c = v.i2c; req_mot = v.mot;
    req_addr = v.addr; req_len = v.len;
    @(posedge clk);
    @(negedge clk) req_valid = 0;
    while (!fin && att < 12) begin
      if (!ch_req_valid) begin
        chk($sformatf("R%0d v%0d request missing", v.req, id), 0, 1);
        break;
      end
      if (att == 0) begin
        chk($sformatf("R1 v%0d cmd", id), 32'(ch_cmd), 32'(v.cmd));
        chk($sformatf("R1 v%0d addr", id), 32'(ch_addr), 32'(v.caddr));
        chk($sformatf("R2 v%0d len", id), 32'(ch_len), 32'(v.len));
      end
      @(posedge clk);
      @(negedge clk);
      s = v.steps[5*((att > 9) ? 9 : att) +: 5];
      ch_rsp_valid = 1; ch_result = s[4:3]; ch_reply = s[2:0]; ch_count = v.cnt;
      @(posedge clk);
      att++;
      @(negedge clk) ch_rsp_valid = 0;
      if (done) fin = 1;
      else begin
        edges = 1;
        while (!ch_req_valid && edges < 2000) begin
          @(posedge clk); edges++; @(negedge clk);
        end
        if (att == 1) gap = edges;
      end
    end
    chk($sformatf("R%0d v%0d status", v.req, id), 32'(status), 32'(v.st));
    chk($sformatf("R8 v%0d acc_len", id), 32'(acc_len), 32'(v.acc));
    chk($sformatf("R%0d v%0d attempts", v.req, id), 32'(att), 32'(v.natt));
    chk($sformatf("R11 v%0d first retry gap", id), 32'(gap), 32'(v.gap));
    st_keep = status;
    @(negedge clk);
    chk($sformatf("R12 v%0d done one cycle", id), 32'(done), 0);
    chk($sformatf("R12 v%0d status held", id), 32'(status), 32'(st_keep));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R12 reset req_ready", 32'(req_ready), 1);
    chk("R12 reset done", 32'(done), 0);
    chk("R2 reset ch_req_valid", 32'(ch_req_valid), 0);
    chk("R8 reset status", 32'(status), 0);
    chk("R8 reset acc_len", 32'(acc_len), 0);

    for (int i = 0; i < NV; i++) run_vec(VT[i], i);

    // R2/R12: channel back-pressure holds request stable
    ch_req_ready = 0;
    @(negedge clk);
    req_valid = 1; req_i2c = 0; req_mot = 0; req_addr = 20'h00ABC; req_len = 2;
    @(posedge clk);
    @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      chk("R2 held valid", 32'(ch_req_valid), 1);
      chk("R2 held addr", 32'(ch_addr), 32'h00ABC);
      chk("R12 busy not ready", 32'(req_ready), 0);
      @(negedge clk);
    end
    req_valid = 0;
    ch_req_ready = 1;
    @(posedge clk);
    @(negedge clk);
    chk("R2 request taken", 32'(ch_req_valid), 0);
    ch_rsp_valid = 1; ch_result = 0; ch_reply = 0; ch_count = 2;
    @(posedge clk);
    @(negedge clk) ch_rsp_valid = 0;
    chk("R8 held-off done", 32'(done), 1);
    chk("R8 held-off status", 32'(status), 0);
    chk("R8 held-off acc_len", 32'(acc_len), 2);
    @(negedge clk);
    chk("R12 idle again", 32'(req_ready), 1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule